// File: doc/BRIEF.md
# Transmit Ready Interrupt Generator

This block decides when a UART transmitter asks for more data. It watches the occupancy count of a 64-entry transmit FIFO, a flag that says the serializer is still shifting a character out, and a handful of mode inputs. From these it drives one interrupt request line. The FIFO storage and the serializer sit outside the block. Only their count and busy flag come in, together with strobes that mark a write into the transmit holding register and a read of the interrupt status.

With the FIFO turned off the request is a plain level: it is high while the holding register is empty. With the FIFO turned on, each drain produces two separate events. The first comes when the count falls through the selected trigger level. The second comes when the FIFO runs dry. In the half-duplex line-turnaround mode the second event is held back until the serializer has also gone idle, so the event marks the moment the line can be released. A pending event stays pending until software writes a byte or reads the interrupt status.

Top module: `txrdy_irq_gen`

## Requirements
- R1: After a synchronous reset, `irq` is low. The trigger detector is disarmed. The FIFO is treated as already empty, so no event is raised just because the count is 0 once reset ends.
- R2: With `fifo_en` low, `irq` equals `irq_en` AND (`fifo_count` == 0) in the same cycle. It is a combinational level with no memory.
- R3: With `fifo_en` high, a cycle in which the detector is armed and `fifo_count` is below the trigger level sets the pending request. `irq` is high from the next clock edge on.
- R4: The trigger event fires once per downward crossing. It is armed again only after a cycle in which `fifo_count` is at or above the trigger level.
- R5: With `fifo_en` high and `rs485_en` low, the count changing from nonzero to 0 sets the pending request at that clock edge. The count staying at 0 raises no further event.
- R6: With `rs485_en` high, the empty event is raised only when the count is 0 and `shift_busy` is low. A 0 count while `shift_busy` is high raises nothing until `shift_busy` falls.
- R7: A high `thr_wr` or `isr_rd` clears the pending request at the next edge. If an event occurs in the same cycle as the strobe, the event wins and the request stays set.
- R8: A trigger crossing and an empty event in the same cycle make one pending request, and a single clearing strobe removes it.
- R9: `trig_sel` encodes the trigger level as 0 → DEPTH/8 (8), 1 → DEPTH/4 (16), 2 → DEPTH/2 (32), 3 → DEPTH − DEPTH/8 (56).
- R10: While `irq_en` is low, `irq` is low and pending state is discarded. Events that occur while it is low are lost and do not appear when it is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single holding register |
| rs485_en | input | 1 | 1 = empty event waits for the serializer to go idle |
| irq_en | input | 1 | Transmit-ready interrupt enable |
| trig_sel | input | 2 | Trigger level select (see R9) |
| fifo_count | input | 7 | Bytes held in the transmit FIFO or holding register |
| shift_busy | input | 1 | Serializer still sending a character |
| thr_wr | input | 1 | One-cycle strobe: write into the holding register |
| isr_rd | input | 1 | One-cycle strobe: read of the interrupt status |
| irq | output | 1 | Transmit-ready interrupt request |

## Verification
Two pairs of functions can collide in one cycle. The first pair is the trigger crossing and the empty event: the count is driven in one step from above the trigger level straight to 0. The check is that the request rises once and that a single status read then drops it. The second pair is setting and clearing: a status-read strobe is driven in the very cycle the count falls below the trigger. The check is that the request is still high afterwards and falls only on the following read.

// File: rtl/txrdy_pkg.sv
// Package: shared types and the trigger-level mapping for the transmit-ready
// interrupt logic. Assumes the FIFO depth is a multiple of 8.
package txrdy_pkg;

    typedef enum logic [1:0] {
        TRIG_EIGHTH    = 2'd0,
        TRIG_QUARTER   = 2'd1,
        TRIG_HALF      = 2'd2,
        TRIG_NEAR_FULL = 2'd3
    } trig_sel_e;

    // Maps a trigger selection onto a byte count for a FIFO of the given depth.
    function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
        case (trig_sel_e'(sel))
            TRIG_EIGHTH:    return depth / 8;
            TRIG_QUARTER:   return depth / 4;
            TRIG_HALF:      return depth / 2;
            default:        return depth - depth / 8;
        endcase
    endfunction

endpackage

// File: rtl/txrdy_trig_detect.sv
// Module: detects the count falling through the selected trigger level.
// It arms while the count is at or above the level and fires once when an
// armed count drops below it. Assumes fifo_count never exceeds DEPTH.
module txrdy_trig_detect #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] fifo_count,
    output logic             cross_evt
);
    localparam int NUM_LVL = 4;

    logic [CNT_W-1:0] lvl_tab [NUM_LVL];
    logic [CNT_W-1:0] lvl_cur;
    logic             armed_q;

    // One table entry per selectable trigger level.
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        assign lvl_tab[g] = CNT_W'(txrdy_pkg::trig_level(2'(g), DEPTH));
    end

    // Pick the level in force this cycle.
    always_comb lvl_cur = lvl_tab[trig_sel];

    // The event is a crossing seen while armed.
    always_comb cross_evt = armed_q && (fifo_count < lvl_cur);

    // Arm at or above the level, disarm once the crossing has been reported.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (fifo_count >= lvl_cur)
            armed_q <= 1'b1;
        else if (cross_evt)
            armed_q <= 1'b0;
    end

endmodule

// File: rtl/txrdy_empty_detect.sv
// Module: detects the transmitter becoming idle. Idle means an empty FIFO and,
// in line-turnaround mode, a serializer that has finished as well. The event
// is the rising edge of that condition. Reset treats the path as idle.
module txrdy_empty_detect #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rs485_en,
    input  logic             shift_busy,
    input  logic [CNT_W-1:0] fifo_count,
    output logic             empty_evt
);
    logic idle_now;
    logic idle_q;

    // Idle condition; the serializer counts only in line-turnaround mode.
    always_comb idle_now = (fifo_count == '0) && !(rs485_en && shift_busy);

    // Rising edge of the idle condition.
    always_comb empty_evt = idle_now && !idle_q;

    // Remember last cycle's idle state; idle after reset, so no spurious event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_q <= 1'b1;
        else
            idle_q <= idle_now;
    end

endmodule

// File: rtl/txrdy_pend.sv
// Module: single pending-request bit for FIFO mode. Any number of
// simultaneous events merge into one request. A set wins over a clear in the
// same cycle. The bit is held at 0 outside FIFO mode or while disabled.
module txrdy_pend #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_en,
    input  logic               irq_en,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic               clr,
    output logic               pend
);
    logic any_set;

    // Merge all event sources.
    always_comb any_set = |set_vec;

    // Hold, set or clear the pending request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (!fifo_en || !irq_en)
            pend <= 1'b0;
        else if (any_set)
            pend <= 1'b1;
        else if (clr)
            pend <= 1'b0;
    end

endmodule

// File: rtl/txrdy_irq_gen.sv
// Module: transmit-ready interrupt generator (top). Without the FIFO the
// request is the holding-register-empty level. With the FIFO it is a pending
// bit set by the trigger crossing and by the empty event. Assumes thr_wr and
// isr_rd are single-cycle strobes and fifo_count is a registered count.
module txrdy_irq_gen #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             rs485_en,
    input  logic             irq_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             shift_busy,
    input  logic             thr_wr,
    input  logic             isr_rd,
    output logic             irq
);
    localparam int NUM_SRC = 2;

    logic               cross_evt;
    logic               empty_evt;
    logic               pend;
    logic [NUM_SRC-1:0] evt_vec;
    logic               clr_req;

    txrdy_trig_detect #(.DEPTH(DEPTH), .CNT_W(CNT_W)) trig_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_sel   (trig_sel),
        .fifo_count (fifo_count),
        .cross_evt  (cross_evt)
    );

    txrdy_empty_detect #(.CNT_W(CNT_W)) empty_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rs485_en   (rs485_en),
        .shift_busy (shift_busy),
        .fifo_count (fifo_count),
        .empty_evt  (empty_evt)
    );

    // Gather event sources and clearing strobes.
    always_comb begin
        evt_vec = {empty_evt, cross_evt};
        clr_req = thr_wr | isr_rd;
    end

    txrdy_pend #(.NUM_SRC(NUM_SRC)) pend_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .irq_en  (irq_en),
        .set_vec (evt_vec),
        .clr     (clr_req),
        .pend    (pend)
    );

    // Output: pending bit in FIFO mode, empty level otherwise, gated by enable.
    always_comb irq = irq_en && (fifo_en ? pend : (fifo_count == '0));

endmodule

// File: rtl/txrdy_irq_chk.sv
// Module: property checker for txrdy_irq_gen, attached by bind. Sees only the
// top-level ports. Assumes the same DEPTH as the design.
module txrdy_irq_chk #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             rs485_en,
    input logic             irq_en,
    input logic [1:0]       trig_sel,
    input logic [CNT_W-1:0] fifo_count,
    input logic             shift_busy,
    input logic             thr_wr,
    input logic             isr_rd,
    input logic             irq
);
    logic [CNT_W-1:0] lvl_now;

    // Trigger level implied by the current selection.
    always_comb lvl_now = CNT_W'(txrdy_pkg::trig_level(trig_sel, DEPTH));

    AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R10

    AST_REG_MODE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && irq) |-> (fifo_count == '0)); // R2

    AST_RISE_BELOW_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && fifo_en && $past(fifo_en) && $past(irq_en))
            |-> ($past(fifo_count) < $past(lvl_now))); // R3

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && irq_en && (thr_wr || isr_rd) && (fifo_count >= lvl_now))
            |=> !(irq && fifo_en)); // R7

    AST_RS485_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rs485_en && shift_busy && (fifo_count == '0)
            && ($past(fifo_count) == '0) && !irq)
            |=> !(irq && fifo_en)); // R6

endmodule

bind txrdy_irq_gen txrdy_irq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/txrdy_irq_gen_tb_top.sv
// Bench: walks a table of stimulus/expected vectors, then directed reset tests.
module txrdy_irq_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int CNT_W      = $clog2(DEPTH + 1);

    typedef struct packed {
        logic             fen;
        logic             r485;
        logic             ien;
        logic [1:0]       sel;
        logic [CNT_W-1:0] cnt;
        logic             bsy;
        logic             wr;
        logic             rd;
        logic             exp_irq;
        logic [3:0]       req;
    } step_t;

    localparam int NV = 41;
    localparam step_t TBL [NV] = '{
        '{1'b0,1'b0,1'b1,2'd0,7'd0, 1'b0,1'b0,1'b0,1'b1,4'd2},  // R2 empty -> high
        '{1'b0,1'b0,1'b1,2'd0,7'd1, 1'b0,1'b0,1'b0,1'b0,4'd2},  // R2 occupied -> low
        '{1'b0,1'b0,1'b1,2'd0,7'd0, 1'b0,1'b0,1'b0,1'b1,4'd2},  // R2
        '{1'b1,1'b0,1'b1,2'd0,7'd0, 1'b0,1'b0,1'b0,1'b0,4'd5},  // R5 no event, stays empty
        '{1'b1,1'b0,1'b1,2'd0,7'd9, 1'b0,1'b0,1'b0,1'b0,4'd3},  // arm
        '{1'b1,1'b0,1'b1,2'd0,7'd8, 1'b0,1'b0,1'b0,1'b0,4'd3},  // R3 at level: none
        '{1'b1,1'b0,1'b1,2'd0,7'd7, 1'b0,1'b0,1'b0,1'b1,4'd3},  // R3 crossing
        '{1'b1,1'b0,1'b1,2'd0,7'd7, 1'b0,1'b0,1'b1,1'b0,4'd7},  // R7 read clears
        '{1'b1,1'b0,1'b1,2'd0,7'd6, 1'b0,1'b0,1'b0,1'b0,4'd4},  // R4 no refire
        '{1'b1,1'b0,1'b1,2'd0,7'd9, 1'b0,1'b0,1'b0,1'b0,4'd4},  // R4 rearm
        '{1'b1,1'b0,1'b1,2'd0,7'd7, 1'b0,1'b0,1'b0,1'b1,4'd4},  // R4 fires again
        '{1'b1,1'b0,1'b1,2'd0,7'd6, 1'b0,1'b1,1'b0,1'b0,4'd7},  // R7 write clears
        '{1'b1,1'b0,1'b1,2'd0,7'd1, 1'b0,1'b0,1'b0,1'b0,4'd5},  // R5
        '{1'b1,1'b0,1'b1,2'd0,7'd0, 1'b0,1'b0,1'b0,1'b1,4'd5},  // R5 empty event
        '{1'b1,1'b0,1'b1,2'd0,7'd0, 1'b0,1'b0,1'b1,1'b0,4'd7},  // R7
        '{1'b1,1'b0,1'b1,2'd0,7'd0, 1'b0,1'b0,1'b0,1'b0,4'd5},  // R5 stays empty, no refire
        '{1'b1,1'b0,1'b1,2'd0,7'd10,1'b0,1'b0,1'b0,1'b0,4'd8},  // R8 arm
        '{1'b1,1'b0,1'b1,2'd0,7'd0, 1'b0,1'b0,1'b0,1'b1,4'd8},  // R8 both at once
        '{1'b1,1'b0,1'b1,2'd0,7'd0, 1'b0,1'b0,1'b1,1'b0,4'd8},  // R8 one read clears
        '{1'b1,1'b0,1'b1,2'd0,7'd9, 1'b0,1'b0,1'b0,1'b0,4'd7},  // arm
        '{1'b1,1'b0,1'b1,2'd0,7'd7, 1'b0,1'b0,1'b1,1'b1,4'd7},  // R7 set beats clear
        '{1'b1,1'b0,1'b1,2'd0,7'd7, 1'b0,1'b0,1'b1,1'b0,4'd7},  // R7
        '{1'b1,1'b1,1'b1,2'd0,7'd3, 1'b1,1'b0,1'b0,1'b0,4'd6},  // R6
        '{1'b1,1'b1,1'b1,2'd0,7'd0, 1'b1,1'b0,1'b0,1'b0,4'd6},  // R6 held
        '{1'b1,1'b1,1'b1,2'd0,7'd0, 1'b1,1'b0,1'b0,1'b0,4'd6},  // R6 held
        '{1'b1,1'b1,1'b1,2'd0,7'd0, 1'b0,1'b0,1'b0,1'b1,4'd6},  // R6 line idle
        '{1'b1,1'b1,1'b1,2'd0,7'd0, 1'b0,1'b0,1'b1,1'b0,4'd7},  // R7
        '{1'b1,1'b1,1'b0,2'd0,7'd9, 1'b0,1'b0,1'b0,1'b0,4'd10}, // R10
        '{1'b1,1'b1,1'b0,2'd0,7'd7, 1'b0,1'b0,1'b0,1'b0,4'd10}, // R10 crossing dropped
        '{1'b1,1'b1,1'b1,2'd0,7'd7, 1'b0,1'b0,1'b0,1'b0,4'd10}, // R10 not replayed
        '{1'b1,1'b1,1'b1,2'd3,7'd56,1'b0,1'b0,1'b0,1'b0,4'd9},  // R9 level 56
        '{1'b1,1'b1,1'b1,2'd3,7'd55,1'b0,1'b0,1'b0,1'b1,4'd9},  // R9
        '{1'b1,1'b1,1'b1,2'd3,7'd55,1'b0,1'b0,1'b1,1'b0,4'd9},  // R9
        '{1'b1,1'b1,1'b1,2'd1,7'd55,1'b0,1'b0,1'b0,1'b0,4'd9},  // R9 level 16 arm
        '{1'b1,1'b1,1'b1,2'd1,7'd16,1'b0,1'b0,1'b0,1'b0,4'd9},  // R9
        '{1'b1,1'b1,1'b1,2'd1,7'd15,1'b0,1'b0,1'b0,1'b1,4'd9},  // R9
        '{1'b1,1'b1,1'b1,2'd1,7'd15,1'b0,1'b0,1'b1,1'b0,4'd9},  // R9
        '{1'b1,1'b1,1'b1,2'd2,7'd32,1'b0,1'b0,1'b0,1'b0,4'd9},  // R9 level 32
        '{1'b1,1'b1,1'b1,2'd2,7'd31,1'b0,1'b0,1'b0,1'b1,4'd9},  // R9
        '{1'b1,1'b1,1'b1,2'd2,7'd31,1'b0,1'b0,1'b1,1'b0,4'd9},  // R9
        '{1'b0,1'b1,1'b0,2'd0,7'd0, 1'b0,1'b0,1'b0,1'b0,4'd10}  // R10 level mode off
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             fifo_en, rs485_en, irq_en, shift_busy, thr_wr, isr_rd;
    logic [1:0]       trig_sel;
    logic [CNT_W-1:0] fifo_count;
    logic             irq;
    int               n_chk  = 0;
    int               n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txrdy_irq_gen #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rs485_en(rs485_en),
        .irq_en(irq_en), .trig_sel(trig_sel), .fifo_count(fifo_count),
        .shift_busy(shift_busy), .thr_wr(thr_wr), .isr_rd(isr_rd), .irq(irq)
    );

    task automatic check(input logic exp, input int req, input string what);
        n_chk++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: irq=%b expected %b", req, what, irq, exp);
        end
    endtask

    task automatic drive(input step_t s);
        fifo_en = s.fen; rs485_en = s.r485; irq_en = s.ien; trig_sel = s.sel;
        fifo_count = s.cnt; shift_busy = s.bsy; thr_wr = s.wr; isr_rd = s.rd;
    endtask

    task automatic tick;
        @(posedge clk);
        #(CLK_PERIOD / 4);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive('{1'b1,1'b0,1'b1,2'd0,7'd0,1'b0,1'b0,1'b0,1'b0,4'd1});
        repeat (3) tick();
        check(1'b0, 1, "irq during reset");                 // R1
        @(negedge clk); rst_n = 1'b1;
        tick(); check(1'b0, 1, "no empty event after reset"); // R1
        tick(); check(1'b0, 1, "still quiet");               // R1

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            tick();
            check(TBL[i].exp_irq, int'(TBL[i].req), $sformatf("vector %0d", i));
        end

        // Directed: reset drops a pending request and disarms the trigger (R1).
        @(negedge clk); drive('{1'b1,1'b0,1'b1,2'd0,7'd9,1'b0,1'b0,1'b0,1'b0,4'd1});
        tick();
        @(negedge clk); fifo_count = 7'd7;
        tick(); check(1'b1, 3, "pending before reset");
        @(negedge clk); rst_n = 1'b0;
        tick(); check(1'b0, 1, "reset clears pending");      // R1
        @(negedge clk); rst_n = 1'b1; fifo_count = 7'd6;
        tick(); check(1'b0, 1, "disarmed after reset");      // R1
        @(negedge clk); fifo_count = 7'd5;
        tick(); check(1'b0, 4, "no crossing without rearm"); // R4

        // Directed: immediate level response in register mode (R2).
        @(negedge clk); fifo_en = 1'b0; fifo_count = 7'd0;
        #1 check(1'b1, 2, "combinational level");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule